// File: doc/BRIEF.md
# Halfword Burst Bus Master with Error Policy

This block is a pipelined bus master for an AHB-Lite style bus. It runs incrementing bursts of halfword beats. Each burst starts from a request that carries a start address, a beat count, a direction and a policy bit. The address phase of one beat overlaps the data phase of the beat before it. The master holds its address and control whenever the slave stretches a cycle with HREADY low.

A slave signals an error in two cycles. In the first, HRESP is ERROR and HREADY is low. In the second, HRESP is ERROR and HREADY is high, and only this second cycle ends the transfer. The policy bit picks what the master does next:

- **Cancel policy.** In the first error cycle the master drops its pending address phase to IDLE, so no further beat is accepted.
- **Continue policy.** The address already on the bus is accepted when HREADY rises, and the burst then carries on at the next address.

The errored beat is reported as failed and is never retried. Every completed data phase produces a status strobe. A done strobe marks the last one and carries a flag telling whether any beat failed.

Top module: `ahb_burst_master`

## Requirements
- R1: After reset, htrans_o is IDLE (2'b00), req_ready_o is 1 and done_o is 0.
- R2: The first beat drives htrans_o = NONSEQ (2'b10) at the start address. Every later beat drives SEQ (2'b11) at the previous address plus 2. hsize_o is 3'b001 (halfword) and hburst_o is 3'b001 (incrementing, undefined length).
- R3: While hready_i is low, haddr_o and htrans_o do not change, except for the cancel case of R6.
- R4: A cycle with hresp_i = 2'b01 (ERROR) and hready_i low completes no beat: beat_valid_o stays 0. beat_valid_o pulses once per data phase, in the cycle where hready_i is high.
- R5: Under the continue policy (req_cont_i = 1), every requested beat is accepted exactly once, at consecutive addresses. The errored beat reports beat_err_o = 1. All other beats report 0. Nothing is retried.
- R6: Under the cancel policy (req_cont_i = 0), ERROR with hready_i low turns htrans_o to IDLE in the next cycle. The pending address is never accepted, and the burst ends after the errored beat, with that beat as its last.
- R7: done_o pulses exactly once, in the cycle the final data phase completes. done_err_o is 1 in that cycle if and only if some beat of the burst got ERROR.
- R8: hwdata_o carries wdata_i for the beat named by wd_idx_o (0-based beat number). It is driven through the cycles after that beat's address is accepted until its data phase ends, and held while hready_i is low.
- R9: For a read, beat_rdata_o equals hrdata_i in the beat's completing cycle, tagged with beat_idx_o.
- R10: A request with req_beats_i = 0 is ignored: htrans_o stays IDLE and req_ready_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Start a burst (taken when req_ready_o is 1) |
| req_addr_i | input | AW | Start address (halfword aligned) |
| req_beats_i | input | CW | Number of beats, 1 or more |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cont_i | input | 1 | 1 = continue after error, 0 = cancel |
| req_ready_o | output | 1 | Master idle, can take a request |
| wdata_i | input | DW | Write data for beat wd_idx_o |
| wd_idx_o | output | CW | Beat number in the data phase |
| beat_valid_o | output | 1 | A data phase completes this cycle |
| beat_idx_o | output | CW | Beat number of the completing phase |
| beat_err_o | output | 1 | Completing beat got ERROR |
| beat_rdata_o | output | DW | Read data of the completing beat |
| done_o | output | 1 | Last data phase of the burst completes |
| done_err_o | output | 1 | Some beat of the burst failed |
| haddr_o | output | AW | Bus address |
| htrans_o | output | 2 | Transfer type |
| hwrite_o | output | 1 | Bus direction |
| hsize_o | output | 3 | Transfer size |
| hburst_o | output | 3 | Burst type |
| hwdata_o | output | DW | Bus write data |
| hrdata_i | input | DW | Bus read data |
| hready_i | input | 1 | Transfer done / wait |
| hresp_i | input | 2 | Slave response |

## Verification
A wrong address-phase state shows at once on the bus. If the address counter steps while HREADY is low, the slave sees a skipped or doubled address at the next accepting edge. If the first/sequential flag is stale, the wrong transfer type appears on the first beat after the start.

A wrong data-phase state is visible through the beat strobes. Completing a beat in the first error cycle gives an extra beat_valid_o. A stale beat index puts the wrong write data on hwdata_o while the slave waits.

A policy fault shows within a cycle or two of the first error cycle. Either the pending address is accepted under cancel, or the bus falls to IDLE under continue. Both change the count of accepted addresses and of reported beats.

// File: rtl/ahb_bm_pkg.sv
package ahb_bm_pkg;
  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] RESP_ERROR = 2'b01;
  localparam logic [2:0] SIZE_HALF  = 3'b001;
  localparam logic [2:0] BURST_INCR = 3'b001;
endpackage

// File: rtl/bm_addr_gen.sv
module bm_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] start_beats_i,
  input  logic          adv_i,
  input  logic          cancel_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] idx_o,
  output logic          first_o
);
  localparam logic [AW-1:0] STEP = AW'(2);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          valid_q, first_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] idx_q, left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      first_q <= 1'b0;
      addr_q  <= '0;
      idx_q   <= '0;
      left_q  <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      first_q <= 1'b1;
      addr_q  <= start_addr_i;
      idx_q   <= '0;
      left_q  <= start_beats_i;
    end else if (valid_q && adv_i) begin
      if (left_q == ONE) begin
        valid_q <= 1'b0;
      end else begin
        addr_q  <= addr_q + STEP;
        idx_q   <= idx_q + ONE;
        left_q  <= left_q - ONE;
        first_q <= 1'b0;
      end
    end else if (cancel_i) begin
      // drop pending address phase in first error cycle
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign idx_o   = idx_q;
  assign first_o = first_q;

  // R2: accepted non-final beat is followed by a sequential beat 2 bytes on
  a_r2_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && adv_i && left_q != ONE && !start_i)
      |=> (valid_q && !first_q && addr_q == $past(addr_q) + STEP));

  // R3: address phase frozen while the slave waits
  a_r3_hold_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !adv_i && !cancel_i && !start_i)
      |=> (valid_q && $stable(addr_q) && $stable(first_q)));
endmodule

// File: rtl/bm_data_phase.sv
module bm_data_phase
  import ahb_bm_pkg::*;
#(
  parameter int CW = 5,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hready_i,
  input  logic [1:0]    hresp_i,
  input  logic [DW-1:0] hrdata_i,
  input  logic          a_valid_i,
  input  logic [CW-1:0] a_idx_i,
  input  logic          write_i,
  input  logic          cont_i,
  input  logic [DW-1:0] wdata_i,
  output logic          d_valid_o,
  output logic [CW-1:0] d_idx_o,
  output logic          cancel_o,
  output logic          beat_valid_o,
  output logic          beat_err_o,
  output logic [DW-1:0] beat_rdata_o,
  output logic [DW-1:0] hwdata_o
);
  logic          d_valid_q;
  logic [CW-1:0] d_idx_q;
  logic          err_now;

  assign err_now = (hresp_i == RESP_ERROR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_valid_q <= 1'b0;
      d_idx_q   <= '0;
    end else if (hready_i) begin
      d_valid_q <= a_valid_i;
      d_idx_q   <= a_idx_i;
    end
  end

  assign cancel_o     = d_valid_q && !hready_i && err_now && !cont_i;
  assign beat_valid_o = d_valid_q && hready_i;
  assign beat_err_o   = beat_valid_o && err_now;
  assign beat_rdata_o = (beat_valid_o && !write_i) ? hrdata_i : '0;
  assign hwdata_o     = (d_valid_q && write_i) ? wdata_i : '0;
  assign d_valid_o    = d_valid_q;
  assign d_idx_o      = d_idx_q;

  // R8: beat in data phase does not change while the slave waits
  a_r8_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid_q && !hready_i) |=> (d_valid_q && $stable(d_idx_q)));

  // R6: cancel request empties the address phase by the next cycle
  a_r6_cancel_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_o |=> !a_valid_i);
endmodule

// File: rtl/ahb_burst_master.sv
module ahb_burst_master
  import ahb_bm_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 5,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [CW-1:0] req_beats_i,
  input  logic          req_write_i,
  input  logic          req_cont_i,
  output logic          req_ready_o,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] wd_idx_o,
  output logic          beat_valid_o,
  output logic [CW-1:0] beat_idx_o,
  output logic          beat_err_o,
  output logic [DW-1:0] beat_rdata_o,
  output logic          done_o,
  output logic          done_err_o,
  output logic [AW-1:0] haddr_o,
  output logic [1:0]    htrans_o,
  output logic          hwrite_o,
  output logic [2:0]    hsize_o,
  output logic [2:0]    hburst_o,
  output logic [DW-1:0] hwdata_o,
  input  logic [DW-1:0] hrdata_i,
  input  logic          hready_i,
  input  logic [1:0]    hresp_i
);
  logic          busy_q, write_q, cont_q, err_seen_q;
  logic          start;
  logic          a_valid, a_first, cancel;
  logic [AW-1:0] a_addr;
  logic [CW-1:0] a_idx;
  logic          d_valid;
  logic [CW-1:0] d_idx;
  trans_e        trans;

  assign start = req_valid_i && !busy_q && (req_beats_i != '0);

  bm_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_addr_i (req_addr_i),
    .start_beats_i(req_beats_i),
    .adv_i        (hready_i),
    .cancel_i     (cancel),
    .valid_o      (a_valid),
    .addr_o       (a_addr),
    .idx_o        (a_idx),
    .first_o      (a_first)
  );

  bm_data_phase #(.CW(CW), .DW(DW)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hready_i    (hready_i),
    .hresp_i     (hresp_i),
    .hrdata_i    (hrdata_i),
    .a_valid_i   (a_valid),
    .a_idx_i     (a_idx),
    .write_i     (write_q),
    .cont_i      (cont_q),
    .wdata_i     (wdata_i),
    .d_valid_o   (d_valid),
    .d_idx_o     (d_idx),
    .cancel_o    (cancel),
    .beat_valid_o(beat_valid_o),
    .beat_err_o  (beat_err_o),
    .beat_rdata_o(beat_rdata_o),
    .hwdata_o    (hwdata_o)
  );

  assign done_o     = busy_q && d_valid && hready_i && !a_valid;
  assign done_err_o = done_o && (err_seen_q || beat_err_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      write_q    <= 1'b0;
      cont_q     <= 1'b0;
      err_seen_q <= 1'b0;
    end else if (start) begin
      busy_q     <= 1'b1;
      write_q    <= req_write_i;
      cont_q     <= req_cont_i;
      err_seen_q <= 1'b0;
    end else begin
      if (beat_err_o) err_seen_q <= 1'b1;
      if (done_o)     busy_q     <= 1'b0;
    end
  end

  always_comb begin
    if (!a_valid)     trans = TR_IDLE;
    else if (a_first) trans = TR_NSEQ;
    else              trans = TR_SEQ;
  end

  assign htrans_o    = trans;
  assign haddr_o     = a_addr;
  assign hwrite_o    = a_valid && write_q;
  assign hsize_o     = SIZE_HALF;
  assign hburst_o    = BURST_INCR;
  assign req_ready_o = !busy_q;
  assign wd_idx_o    = d_idx;
  assign beat_idx_o  = d_idx;

  // R7: after the done strobe the bus is idle and a new request can be taken
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (req_ready_o && htrans_o == 2'b00));

  // R6: first error cycle under cancel policy leaves the bus idle next cycle
  a_r6_bus_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && d_valid && !hready_i && hresp_i == RESP_ERROR && !cont_q)
      |=> (htrans_o == 2'b00));

  // R4: no beat completes while the slave holds hready low
  a_r4_no_early_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_valid && !hready_i) |=> d_valid);
endmodule

// File: tb/sim_ahb_burst_master.sv
`timescale 1ns/1ps
module sim_ahb_burst_master;
  localparam int AW = 32;
  localparam int CW = 5;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_beats = '0;
  logic          req_write = 1'b0;
  logic          req_cont = 1'b0;
  logic          req_ready;
  logic [DW-1:0] wdata;
  logic [CW-1:0] wd_idx;
  logic          beat_valid, beat_err, done, done_err;
  logic [CW-1:0] beat_idx;
  logic [DW-1:0] beat_rdata;
  logic [AW-1:0] haddr;
  logic [1:0]    htrans;
  logic          hwrite;
  logic [2:0]    hsize, hburst;
  logic [DW-1:0] hwdata, hrdata;
  logic          hready_s;
  logic [1:0]    hresp_s;

  always #5 clk = ~clk;

  ahb_burst_master #(.AW(AW), .CW(CW), .DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_beats_i(req_beats),
    .req_write_i(req_write), .req_cont_i(req_cont), .req_ready_o(req_ready),
    .wdata_i(wdata), .wd_idx_o(wd_idx),
    .beat_valid_o(beat_valid), .beat_idx_o(beat_idx), .beat_err_o(beat_err),
    .beat_rdata_o(beat_rdata), .done_o(done), .done_err_o(done_err),
    .haddr_o(haddr), .htrans_o(htrans), .hwrite_o(hwrite), .hsize_o(hsize),
    .hburst_o(hburst), .hwdata_o(hwdata), .hrdata_i(hrdata),
    .hready_i(hready_s), .hresp_i(hresp_s)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [DW-1:0] wd_fn(input int i);
    return 16'hA500 + DW'(i);
  endfunction
  function automatic logic [DW-1:0] rd_fn(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h3C3C;
  endfunction

  assign wdata = wd_fn(int'(wd_idx));

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // slave model configuration
  int            cfg_wait = 0;
  bit            cfg_err_en = 1'b0;
  logic [AW-1:0] cfg_err_addr = '0;
  logic [AW-1:0] cfg_base = '0;
  bit            cfg_cont = 1'b0;

  logic          s_act, s_err, s_e1, s_write;
  logic [AW-1:0] s_addr;
  int            s_rem;
  logic          err_hit;

  assign err_hit = cfg_err_en && (haddr == cfg_err_addr);
  assign hrdata  = rd_fn(s_addr);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hready_s <= 1'b1; hresp_s <= 2'b00; s_act <= 1'b0; s_rem <= 0;
      s_err <= 1'b0; s_e1 <= 1'b0; s_addr <= '0; s_write <= 1'b0;
    end else if (hready_s) begin
      s_act <= htrans[1];
      if (htrans[1]) begin
        s_addr <= haddr; s_write <= hwrite; s_err <= err_hit; s_e1 <= 1'b0;
        if (cfg_wait > 0) begin
          hready_s <= 1'b0; hresp_s <= 2'b00; s_rem <= cfg_wait - 1;
        end else if (err_hit) begin
          hready_s <= 1'b0; hresp_s <= 2'b01; s_rem <= 0; s_e1 <= 1'b1;
        end else begin
          hready_s <= 1'b1; hresp_s <= 2'b00;
        end
      end else begin
        hready_s <= 1'b1; hresp_s <= 2'b00;
      end
    end else begin
      if (s_rem > 0) s_rem <= s_rem - 1;
      else if (s_err && !s_e1) begin hresp_s <= 2'b01; s_e1 <= 1'b1; end
      else begin hready_s <= 1'b1; hresp_s <= s_err ? 2'b01 : 2'b00; end
    end
  end

  // monitor logs
  logic [AW-1:0] acc_addr [32];
  logic [1:0]    acc_tr   [32];
  int            acc_n = 0;
  logic [CW-1:0] bt_idx [32];
  logic          bt_err [32];
  logic [DW-1:0] bt_rd  [32];
  int            bt_n = 0;
  int            done_n = 0;
  logic          done_err_l = 1'b0;
  logic          p_wait = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [1:0]    p_tr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hready_s && htrans[1] && acc_n < 32) begin
        acc_addr[acc_n] = haddr; acc_tr[acc_n] = htrans; acc_n++;
      end
      if (beat_valid && bt_n < 32) begin
        bt_idx[bt_n] = beat_idx; bt_err[bt_n] = beat_err;
        bt_rd[bt_n] = beat_rdata; bt_n++;
      end
      if (done) begin done_n++; done_err_l = done_err; end
      if (!hready_s && hresp_s == 2'b01)
        check(!beat_valid, "R4", "beat strobe in first error cycle",
              longint'(beat_valid), 0);
      if (s_act && s_write)
        check(hwdata == wd_fn(int'((s_addr - cfg_base) >> 1)), "R8",
              "write data in data phase", longint'(hwdata),
              longint'(wd_fn(int'((s_addr - cfg_base) >> 1))));
      if (p_wait && cfg_cont) begin
        check(haddr == p_addr, "R3", "address held in wait", longint'(haddr),
              longint'(p_addr));
        check(htrans == p_tr, "R3", "htrans held in wait", longint'(htrans),
              longint'(p_tr));
      end
      p_wait = !hready_s && (htrans != 2'b00);
      p_addr = haddr;
      p_tr   = htrans;
    end
  end

  task automatic run_burst(input logic [AW-1:0] base, input int beats,
                           input bit wr, input bit cont, input int waits,
                           input bit een, input int eidx);
    int exp_n;
    int guard;
    bit exp_err;
    cfg_base = base; cfg_wait = waits; cfg_err_en = een; cfg_cont = cont;
    cfg_err_addr = base + AW'(2 * eidx);
    exp_n = (een && !cont && eidx < beats) ? eidx + 1 : beats;
    exp_err = een && (eidx < exp_n);
    @(negedge clk);
    acc_n = 0; bt_n = 0; done_n = 0;
    check(req_ready == 1'b1, "R7", "ready before request", longint'(req_ready), 1);
    req_valid = 1'b1; req_addr = base; req_beats = CW'(beats);
    req_write = wr; req_cont = cont;
    @(negedge clk);
    req_valid = 1'b0;
    check(hsize == 3'b001, "R2", "hsize halfword", longint'(hsize), 1);
    check(hburst == 3'b001, "R2", "hburst incr", longint'(hburst), 1);
    guard = 0;
    while (done_n == 0 && guard < 400) begin
      @(posedge clk);
      guard++;
    end
    check(guard < 400, "R7", "burst finished", longint'(guard), 0);
    repeat (3) @(negedge clk);
    check(acc_n == exp_n, cont ? "R5" : "R6", "accepted addresses",
          longint'(acc_n), longint'(exp_n));
    for (int i = 0; i < exp_n && i < acc_n; i++) begin
      check(acc_addr[i] == base + AW'(2 * i), "R2", "beat address",
            longint'(acc_addr[i]), longint'(base + AW'(2 * i)));
      check(acc_tr[i] == ((i == 0) ? 2'b10 : 2'b11), "R2", "beat htrans",
            longint'(acc_tr[i]), (i == 0) ? 2 : 3);
    end
    check(bt_n == exp_n, "R4", "beat strobes", longint'(bt_n), longint'(exp_n));
    for (int i = 0; i < exp_n && i < bt_n; i++) begin
      check(bt_idx[i] == CW'(i), "R9", "beat index", longint'(bt_idx[i]), i);
      check(bt_err[i] == (een && i == eidx), "R5", "beat status",
            longint'(bt_err[i]), longint'(een && i == eidx));
      if (!wr)
        check(bt_rd[i] == rd_fn(base + AW'(2 * i)), "R9", "read data",
              longint'(bt_rd[i]), longint'(rd_fn(base + AW'(2 * i))));
    end
    check(done_n == 1, "R7", "done count", longint'(done_n), 1);
    check(done_err_l == exp_err, "R7", "done error flag",
          longint'(done_err_l), longint'(exp_err));
    check(htrans == 2'b00, "R6", "bus idle after burst", longint'(htrans), 0);
  endtask

  task automatic t_reset;
    check(htrans == 2'b00, "R1", "htrans at reset", longint'(htrans), 0);
    check(req_ready == 1'b1, "R1", "ready at reset", longint'(req_ready), 1);
    check(done == 1'b0, "R1", "done at reset", longint'(done), 0);
  endtask

  task automatic t_read_plain;      run_burst(32'h100, 4, 0, 1, 0, 0, 0); endtask
  task automatic t_write_waits;     run_burst(32'h200, 3, 1, 1, 2, 0, 0); endtask
  task automatic t_err_continue;    run_burst(32'h300, 5, 0, 1, 0, 1, 2); endtask
  task automatic t_err_cancel;      run_burst(32'h400, 5, 0, 0, 0, 1, 1); endtask
  task automatic t_err_cancel_first; run_burst(32'h600, 3, 1, 0, 0, 1, 0); endtask
  task automatic t_err_last_waits;  run_burst(32'h500, 3, 1, 1, 1, 1, 2); endtask
  task automatic t_err_cont_waits;  run_burst(32'h700, 4, 1, 1, 2, 1, 1); endtask

  task automatic t_zero_count;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h800; req_beats = '0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(htrans == 2'b00, "R10", "zero count keeps bus idle", longint'(htrans), 0);
    check(req_ready == 1'b1, "R10", "zero count keeps ready", longint'(req_ready), 1);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read_plain();
    t_write_waits();
    t_err_continue();
    t_err_cancel();
    t_err_cancel_first();
    t_err_last_waits();
    t_err_cont_waits();
    t_zero_count();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule